// File: doc/BRIEF.md
# Hybrid Lookahead-Ripple Times-Three Multiplier

This block forms the exact product 3·N of an unsigned operand without a multiplier array. It adds the operand to a copy of itself shifted left by one place, and the result is two bits wider than the input. The logic is purely combinational. It drops into a datapath wherever a fixed factor of three is needed, for example a radix-8 recoder or a filter tap.

The adder is not a plain ripple chain. Each bit carries a pair of conditional-carry flags instead of one carry: flag W0 means "operand bit and carry both set" and flag W1 means "operand bit or carry set". The operand is cut into 8-bit slices, and the slices are chained one after another. Inside a slice, two 4-bit term builders reduce their nibble to a compact (R, Q) form. A two-group lookahead uses those terms to produce the pair at the slice's midpoint and at its top. Two nibble function units then expand the pair into the sum bits. Only the pair crosses from one slice to the next.

Top module: `triple_hybrid_adder`

## Requirements
- R1: For every 32-bit input value, the 34-bit output equals three times the input, read as unsigned integers.
- R2: An input of all zeros gives an output of all zeros, and that includes the state right after reset, when the input is held at zero.
- R3: An input of all ones (0xFFFF_FFFF) gives 0x2_FFFF_FFFD.
- R4: The input 0x5555_5555 gives 0x0_FFFF_FFFF, and the input 0xAAAA_AAAA gives 0x1_FFFF_FFFE.
- R5: For each position j from 0 to 31, an input with only bit j set gives an output with exactly bits j and j+1 set.
- R6: Output bit 0 always equals input bit 0.
- R7: When input bit 31 is clear, output bit 33 is clear.
- R8: A carry that starts in the lowest slice travels through every slice. For example, 0x5555_5557 gives 0x1_0000_0005.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| n_in | input | 32 | Unsigned operand N |
| triple_out | output | 34 | Unsigned product 3·N |

## Verification
The degenerate operands are zero and all ones. The alternating patterns 0x5555_5555 and 0xAAAA_AAAA put every bit pair in the state where the carry only propagates, so a fault in the propagate (Q) terms shows up in the result. The input 0x5555_5557 starts a carry in the lowest nibble and relies on every slice link and every lookahead unit to pass it to the top bits. A single set bit walked across all 32 positions finds a sum or term error that is tied to one bit position. Several hundred random operands mix generate and propagate cases in every nibble, and they also serve to check the bit-0 and top-bit properties.

// File: rtl/triple_pkg.sv
`timescale 1ns/1ps
package triple_pkg;

  localparam int GRP_W = 4;                 // bits per term builder
  localparam int MOD_W = 8;                 // bits per chained slice
  localparam int GRPS  = MOD_W / GRP_W;     // term builders per slice

  // Conditional-carry pair at one bit position:
  // w0 = a_i AND c_i, w1 = a_i OR c_i
  typedef struct packed {
    logic w0;
    logic w1;
  } cpair_t;

  // Nibble terms: pair_out.w0 = r0 | q0&pair_in.w0, pair_out.w1 = r1 | q1&pair_in.w1
  typedef struct packed {
    logic r0;
    logic q0;
    logic r1;
    logic q1;
  } gterm_t;

  // One bit of pair advance: w0' = a & w1, w1' = a | w0
  function automatic cpair_t pair_step(input logic a, input cpair_t p);
    cpair_t r;
    r.w0 = a & p.w1;
    r.w1 = a | p.w0;
    return r;
  endfunction

  // Four steps of pair_step folded into (R, Q) form
  function automatic gterm_t group_terms(input logic [GRP_W-1:0] a);
    gterm_t t;
    t.r0 = (a[3] & a[2]) | (a[3] & a[1] & a[0]);
    t.q0 = a[3] & a[1];
    t.r1 = a[3] | (a[2] & a[1]);
    t.q1 = a[2] & a[0];
    return t;
  endfunction

  function automatic cpair_t apply_terms(input gterm_t t, input cpair_t p);
    cpair_t r;
    r.w0 = t.r0 | (t.q0 & p.w0);
    r.w1 = t.r1 | (t.q1 & p.w1);
    return r;
  endfunction

  // Compose an upper nibble's terms over a lower nibble's terms
  function automatic gterm_t merge_terms(input gterm_t hi, input gterm_t lo);
    gterm_t t;
    t.r0 = hi.r0 | (hi.q0 & lo.r0);
    t.q0 = hi.q0 & lo.q0;
    t.r1 = hi.r1 | (hi.q1 & lo.r1);
    t.q1 = hi.q1 & lo.q1;
    return t;
  endfunction

  // s_i = a_i ^ a_{i-1} ^ c_{i-1}; a_{i-1}^c_{i-1} equals w1 & ~w0 of bit i-1
  function automatic logic sum_bit(input logic a, input cpair_t p_below);
    return a ^ (p_below.w1 & ~p_below.w0);
  endfunction

endpackage

// File: rtl/triple_grpgen.sv
`timescale 1ns/1ps
module triple_grpgen
  import triple_pkg::*;
(
  input  logic [GRP_W-1:0] a,
  output gterm_t           terms
);
  assign terms = group_terms(a);
endmodule

// File: rtl/triple_la2.sv
`timescale 1ns/1ps
module triple_la2
  import triple_pkg::*;
(
  input  gterm_t t_lo,
  input  gterm_t t_hi,
  input  cpair_t c_in,
  output cpair_t c_mid,
  output cpair_t c_out
);
  // Both results come straight from c_in: no ripple through the midpoint
  assign c_mid = apply_terms(t_lo, c_in);
  assign c_out = apply_terms(merge_terms(t_hi, t_lo), c_in);
endmodule

// File: rtl/triple_fu4.sv
`timescale 1ns/1ps
module triple_fu4
  import triple_pkg::*;
(
  input  logic [GRP_W-1:0] a,
  input  cpair_t           c_in,
  output logic [GRP_W-1:0] s
);
  always_comb begin
    cpair_t p;
    p = c_in;
    for (int i = 0; i < GRP_W; i++) begin
      s[i] = sum_bit(a[i], p);
      p    = pair_step(a[i], p);
    end
  end
endmodule

// File: rtl/triple_lamod.sv
`timescale 1ns/1ps
module triple_lamod
  import triple_pkg::*;
(
  input  logic [MOD_W-1:0] a,
  input  cpair_t           c_in,
  output cpair_t           c_out,
  output logic [MOD_W-1:0] s
);
  gterm_t grp_t   [GRPS];
  cpair_t grp_cin [GRPS];
  cpair_t c_mid;

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    triple_grpgen u_gen (
      .a     (a[g*GRP_W +: GRP_W]),
      .terms (grp_t[g])
    );
  end

  triple_la2 u_la2 (
    .t_lo  (grp_t[0]),
    .t_hi  (grp_t[1]),
    .c_in  (c_in),
    .c_mid (c_mid),
    .c_out (c_out)
  );

  assign grp_cin[0] = c_in;
  assign grp_cin[1] = c_mid;

  for (genvar g = 0; g < GRPS; g++) begin : g_fu
    triple_fu4 u_fu (
      .a    (a[g*GRP_W +: GRP_W]),
      .c_in (grp_cin[g]),
      .s    (s[g*GRP_W +: GRP_W])
    );
  end
endmodule

// File: rtl/triple_hybrid_adder.sv
`timescale 1ns/1ps
module triple_hybrid_adder
  import triple_pkg::*;
#(
  parameter int DATA_W = 32              // multiple of MOD_W
) (
  input  logic [DATA_W-1:0] n_in,
  output logic [DATA_W+1:0] triple_out
);
  localparam int MODS = DATA_W / MOD_W;

  // Pair at each slice boundary; index m is the pair just below slice m
  logic [MODS:0]     bnd_w0;
  logic [MODS:0]     bnd_w1;
  logic [DATA_W-1:0] sum_lo;
  cpair_t            top_pair;

  // Below bit 0 the shifted operand contributes zero and no carry exists
  assign bnd_w0[0] = 1'b0;
  assign bnd_w1[0] = 1'b0;

  for (genvar m = 0; m < MODS; m++) begin : g_mod
    cpair_t cin_m;
    cpair_t cout_m;
    assign cin_m.w0 = bnd_w0[m];
    assign cin_m.w1 = bnd_w1[m];

    triple_lamod u_mod (
      .a     (n_in[m*MOD_W +: MOD_W]),
      .c_in  (cin_m),
      .c_out (cout_m),
      .s     (sum_lo[m*MOD_W +: MOD_W])
    );

    assign bnd_w0[m+1] = cout_m.w0;
    assign bnd_w1[m+1] = cout_m.w1;
  end

  assign top_pair.w0 = bnd_w0[MODS];
  assign top_pair.w1 = bnd_w1[MODS];

  // Bit DATA_W adds only a_{DATA_W-1} and its carry; bit DATA_W+1 is the final carry
  assign triple_out[DATA_W-1:0] = sum_lo;
  assign triple_out[DATA_W]     = sum_bit(1'b0, top_pair);
  assign triple_out[DATA_W+1]   = top_pair.w0;
endmodule

// File: rtl/triple_hybrid_adder_chk.sv
`timescale 1ns/1ps
module triple_hybrid_adder_chk #(
  parameter int DATA_W = 32,
  parameter int MODS   = 4
) (
  input logic [DATA_W-1:0] n_in,
  input logic [DATA_W+1:0] triple_out,
  input logic [MODS:0]     bnd_w0,
  input logic [MODS:0]     bnd_w1
);
  always_comb begin
    a_r1_product: assert (triple_out == ({2'b00, n_in} + {1'b0, n_in, 1'b0}))
      else $error("R1 product mismatch");
    a_r2_zero: assert (!(n_in == '0) || (triple_out == '0))
      else $error("R2 zero input gives nonzero output");
    a_r6_lsb: assert (triple_out[0] == n_in[0])
      else $error("R6 lsb mismatch");
    a_r7_top_clear: assert (n_in[DATA_W-1] || !triple_out[DATA_W+1])
      else $error("R7 top bit set with clear input msb");
  end

  // R1: a carry-and-bit flag can never be set while the carry-or-bit flag is clear
  for (genvar g = 0; g <= MODS; g++) begin : g_pair
    always_comb begin
      a_r1_pair_order: assert (!(bnd_w0[g] && !bnd_w1[g]))
        else $error("R1 pair order broken at boundary %0d", g);
    end
  end
endmodule

bind triple_hybrid_adder triple_hybrid_adder_chk #(
  .DATA_W (DATA_W),
  .MODS   (MODS)
) u_chk (
  .n_in       (n_in),
  .triple_out (triple_out),
  .bnd_w0     (bnd_w0),
  .bnd_w1     (bnd_w1)
);

// File: tb/triple_hybrid_adder_bench.sv
`timescale 1ns/1ps
module triple_hybrid_adder_bench;

  typedef struct {
    logic [31:0] n;
    logic [33:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] n_in = '0;
  logic [33:0] triple_out;

  item_t sb_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  always #2 clk = ~clk;   // 4 ns period

  triple_hybrid_adder u_triple_hybrid_adder (
    .n_in       (n_in),
    .triple_out (triple_out)
  );

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic push(input logic [31:0] v, input logic [33:0] e, input string tag);
    item_t it;
    @(posedge clk);
    n_in   = v;
    it.n   = v;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  function automatic logic [33:0] times3(input logic [31:0] v);
    return {2'b00, v} * 34'd3;
  endfunction

  // Monitor: sample half a period after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (triple_out !== it.exp) begin
          errors++;
          $display("FAIL %s n=%h actual=%h expected=%h", it.tag, it.n, triple_out, it.exp);
        end
        // R6: bit 0 passes through
        checks++;
        if (triple_out[0] !== it.n[0]) begin
          errors++;
          $display("FAIL R6 n=%h actual=%b expected=%b", it.n, triple_out[0], it.n[0]);
        end
        // R7: top bit clear when input msb clear
        if (!it.n[31]) begin
          checks++;
          if (triple_out[33] !== 1'b0) begin
            errors++;
            $display("FAIL R7 n=%h actual=%b expected=0", it.n, triple_out[33]);
          end
        end
      end
    end
  end

  // Driver
  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R2: state after reset with input held at zero
    push(32'h0000_0000, 34'h0_0000_0000, "R2");
    push(32'hFFFF_FFFF, 34'h2_FFFF_FFFD, "R3");
    push(32'h5555_5555, 34'h0_FFFF_FFFF, "R4");
    push(32'hAAAA_AAAA, 34'h1_FFFF_FFFE, "R4");
    push(32'h5555_5557, 34'h1_0000_0005, "R8");
    push(32'h0000_0000, 34'h0_0000_0000, "R2");
    for (int j = 0; j < 32; j++) begin
      push(32'h1 << j, 34'h3 << j, "R5");
    end
    push(32'h8000_0000, 34'h1_8000_0000, "R5");
    push(32'h7FFF_FFFF, 34'h1_7FFF_FFFD, "R1");
    for (int k = 0; k < 400; k++) begin
      logic [31:0] v;
      v = $urandom();
      push(v, times3(v), "R1");
    end
    repeat (4) @(posedge clk);
    wait (sb_q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    report();
    $finish;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule